// File: doc/BRIEF.md
# Multi-Core External Interrupt Router

The router accepts a wide vector of level-sensitive interrupt inputs and delivers each one to a single core and to one of four output lines on that core. Inputs are organised in 32-bit groups. Every input has an enable bit and a core-route byte. Every group has one line-route byte. Each core sees a status bank that software acknowledges by writing ones. Each of a core's four output lines is the OR of the inputs currently pending on that core and line.

Software reaches the block through a simple 32-bit word-addressed register port. The accessing core sends its index with each access, and that index selects which status bank is read or cleared. Enable and route changes act at once on interrupts that are already live. A newly enabled input that is already high is delivered. A newly disabled input is withdrawn. A re-routed input moves from its old core to its new core. All state updates caused by one write or one input edge happen in a single clock cycle. The core outputs are registered, so they follow the internal state one cycle later.

Top module: `ext_irq_router`

## Requirements
- R1: The raw word at address 0x30+g reads input levels 32g..32g+31 and follows them whatever the enable state, one cycle after each input change.
- R2: The line-route byte for group g is byte g%4 of the word at 0x10+g/4. The line index is the position of the lowest set bit. A zero byte, or a lowest set bit at position 4 or above, selects line 0.
- R3: The core-route byte for input n is byte n%4 (little-endian) of the word at 0x80+n/4. When config bit 0 is clear, the core is the position of the lowest set bit, falling back to core 0 when the byte is zero or that position is 4 or above.
- R4: When config bit 0 (word 0x00) is set, the core-route byte value itself is the core index.
- R5: A decoded core index of NUM_CORE or more is ignored. The previous route stays in force, but the written byte still reads back.
- R6: A rising input that is enabled (enable word 0x20+g) sets its bit in the routed core's status bank and makes it pending. A disabled rising input changes only the raw word.
- R7: Output core_irq[4c+l] is high, one cycle after the state update, exactly while at least one input is pending on core c, line l. It stays high until the last such input leaves.
- R8: An enable write delivers every newly enabled input whose level is high, and withdraws every newly disabled input that is pending.
- R9: The status word at 0x40+g reads and write-one-to-clears the bank of the core given on bus_core. A cleared bit stops being pending.
- R10: A core-route change for an input that is high and enabled withdraws it from the old core and delivers it to the new core in the same cycle.
- R11: A line-route write does not move inputs that are already pending.
- R12: A falling input is removed from every status bank and from the pending sets.
- R13: After reset, all enables, status, routes and config are zero and every output is low.
- R14: Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Level interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_core | input | CW | Index of the accessing core |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| core_irq | output | 4*NUM_CORE | Per-core output lines, bit 4c+l |

## Verification
The bench first raises an input while it is disabled, then enables it, to show that the raw and pending paths are separate. It routes inputs with one-hot bytes, with encoded bytes, with out-of-range bytes and with bytes whose lowest set bit is high, so that each decode branch produces a different output bit. Live inputs are then moved between cores, rewritten in their line route, acknowledged and disabled, to tell apart state that moves from state that stays. Two inputs sharing one line show that the OR drops only when the last of them falls.

// File: rtl/ext_irq_router.sv
module ext_irq_router #(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_CORE = 4,
  localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_IRQ-1:0]    irq_in,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic [CW-1:0]         bus_core,
  output logic [31:0]           bus_rdata,
  output logic [4*NUM_CORE-1:0] core_irq
);
  localparam int NG = NUM_IRQ / 32;
  localparam logic [8:0] NC9 = 9'(NUM_CORE);

  logic                enc_mode;
  logic [7:0]          line_sel [NG];
  logic [7:0]          core_sel [NUM_IRQ];
  logic [NUM_IRQ-1:0]  raw, en, en_n;
  logic [NUM_IRQ-1:0]  st [NUM_CORE];
  logic [NUM_IRQ-1:0]  st_n [NUM_CORE];
  logic [CW-1:0]       rt [NUM_IRQ];
  logic [CW-1:0]       rt_n [NUM_IRQ];
  logic [1:0]          dl [NUM_IRQ];
  logic [1:0]          dl_n [NUM_IRQ];
  logic [4*NUM_CORE-1:0] pend;
  logic [31:0]         rd_val;

  wire [3:0] rgn    = bus_addr[7:4];
  wire [3:0] idx    = bus_addr[3:0];
  wire       is_cs  = bus_addr[7];
  wire       core_ok = {{(9-CW){1'b0}}, bus_core} < NC9;
  wire       wr_en  = bus_wr && !is_cs && rgn == 4'h2;
  wire       wr_st  = bus_wr && !is_cs && rgn == 4'h4 && core_ok;
  wire       wr_cs  = bus_wr && is_cs;

  function automatic logic [1:0] low2(input logic [7:0] v);
    if (v[0]) return 2'd0;
    if (v[1]) return 2'd1;
    if (v[2]) return 2'd2;
    if (v[3]) return 2'd3;
    return 2'd0;
  endfunction

  always_comb begin
    en_n = en;
    for (int c = 0; c < NUM_CORE; c++) st_n[c] = st[c];
    for (int i = 0; i < NUM_IRQ; i++) begin
      logic [7:0] cid;
      rt_n[i] = rt[i];
      dl_n[i] = dl[i];
      cid = enc_mode ? core_sel[i] : 8'd0;
      if (raw[i] && !irq_in[i])
        for (int c = 0; c < NUM_CORE; c++) st_n[c][i] = 1'b0;
      if (!raw[i] && irq_in[i] && en[i]) begin
        st_n[rt[i]][i] = 1'b1;
        dl_n[i] = low2(line_sel[i/32]);
      end
      if (wr_en && (i / 32) == int'(idx)) begin
        en_n[i] = bus_wdata[i%32];
        if (bus_wdata[i%32] && !en[i] && irq_in[i]) begin
          st_n[rt[i]][i] = 1'b1;
          dl_n[i] = low2(line_sel[i/32]);
        end
        if (!bus_wdata[i%32] && en[i])
          for (int c = 0; c < NUM_CORE; c++) st_n[c][i] = 1'b0;
      end
      if (wr_st && (i / 32) == int'(idx) && bus_wdata[i%32])
        st_n[bus_core][i] = 1'b0;
      if (wr_cs && (i / 4) == int'(bus_addr[6:0])) begin
        cid = enc_mode ? bus_wdata[8*(i%4) +: 8] : {6'd0, low2(bus_wdata[8*(i%4) +: 8])};
        if ({1'b0, cid} < NC9 && cid[CW-1:0] != rt[i]) begin
          rt_n[i] = cid[CW-1:0];
          for (int c = 0; c < NUM_CORE; c++) st_n[c][i] = 1'b0;
          if (irq_in[i] && en[i]) begin
            st_n[cid[CW-1:0]][i] = 1'b1;
            dl_n[i] = low2(line_sel[i/32]);
          end
        end
      end
    end
  end

  always_comb begin
    pend = '0;
    for (int c = 0; c < NUM_CORE; c++)
      for (int i = 0; i < NUM_IRQ; i++)
        if (st[c][i]) pend[4*c + int'(dl[i])] = 1'b1;
  end

  always_comb begin
    rd_val = '0;
    if (is_cs) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if ((i / 4) == int'(bus_addr[6:0])) rd_val[8*(i%4) +: 8] = core_sel[i];
    end else begin
      case (rgn)
        4'h0: if (idx == 4'h0) rd_val[0] = enc_mode;
        4'h1: for (int g = 0; g < NG; g++)
                if ((g / 4) == int'(idx)) rd_val[8*(g%4) +: 8] = line_sel[g];
        4'h2, 4'h3, 4'h4:
              for (int i = 0; i < NUM_IRQ; i++)
                if ((i / 32) == int'(idx))
                  rd_val[i%32] = (rgn == 4'h2) ? en[i] :
                                 (rgn == 4'h3) ? raw[i] :
                                 (core_ok && st[bus_core][i]);
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_mode  <= 1'b0;
      raw       <= '0;
      en        <= '0;
      core_irq  <= '0;
      bus_rdata <= '0;
      for (int g = 0; g < NG; g++) line_sel[g] <= '0;
      for (int c = 0; c < NUM_CORE; c++) st[c] <= '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        core_sel[i] <= '0;
        rt[i]       <= '0;
        dl[i]       <= '0;
      end
    end else begin
      raw      <= irq_in;
      en       <= en_n;
      core_irq <= pend;
      for (int c = 0; c < NUM_CORE; c++) st[c] <= st_n[c];
      for (int i = 0; i < NUM_IRQ; i++) begin
        rt[i] <= rt_n[i];
        dl[i] <= dl_n[i];
        if (wr_cs && (i / 4) == int'(bus_addr[6:0])) core_sel[i] <= bus_wdata[8*(i%4) +: 8];
      end
      if (bus_wr && !is_cs && rgn == 4'h0 && idx == 4'h0) enc_mode <= bus_wdata[0];
      if (bus_wr && !is_cs && rgn == 4'h1)
        for (int g = 0; g < NG; g++)
          if ((g / 4) == int'(idx)) line_sel[g] <= bus_wdata[8*(g%4) +: 8];
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq_chk
    logic [NUM_CORE-1:0] owners;
    for (genvar gc = 0; gc < NUM_CORE; gc++) begin : g_col
      assign owners[gc] = st[gc][gi];
    end
    a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owners));
    a_r6_owner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (|owners) |-> en[gi]);
    a_r12_owner_level_high: assert property (@(posedge clk) disable iff (!rst_n)
      (|owners) |-> raw[gi]);
  end

  for (genvar gc = 0; gc < NUM_CORE; gc++) begin : g_core_chk
    a_r7_line_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (|core_irq[4*gc +: 4]) |-> $past(st[gc] != '0));
  end
endmodule

// File: tb/tb_ext_irq_router.sv
`timescale 1ns/1ps
module tb_ext_irq_router;
  localparam int NI = 64;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NI-1:0] irq = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_core = '0;
  logic [31:0] bus_rdata;
  logic [15:0] core_irq;

  int nchk = 0, nfail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ext_irq_router #(.NUM_IRQ(NI), .NUM_CORE(NC)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_core(bus_core),
    .bus_rdata(bus_rdata), .core_irq(core_irq));

  always @(posedge clk) begin
    if (bus_rd) begin
      #1;
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL scoreboard empty rdata=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          nfail++;
          $display("FAIL %s rdata=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] c = 2'd0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_core = c;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] c, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_core = c;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_in(input int n, input logic v);
    @(negedge clk);
    irq[n] = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic [15:0] e, input string t);
    @(negedge clk);
    nchk++;
    if (core_irq !== e) begin
      nfail++;
      $display("FAIL %s core_irq=%h exp=%h", t, core_irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(16'h0000, "R13 outputs low after reset");
    rd(8'h20, 0, 32'h0, "R13 enable clear");
    rd(8'h80, 0, 32'h0, "R13 route clear");
    rd(8'h00, 0, 32'h0, "R13 config clear");

    set_in(3, 1'b1);
    chk_irq(16'h0000, "R6 disabled input does not fire");
    rd(8'h30, 0, 32'h8, "R1 raw follows disabled input");
    rd(8'h40, 0, 32'h0, "R6 disabled input leaves status");

    wr(8'h20, 32'h8);
    chk_irq(16'h0001, "R8 enabling high input delivers");
    rd(8'h40, 0, 32'h8, "R8 status after enable");

    set_in(3, 1'b0);
    chk_irq(16'h0000, "R12 falling input withdrawn");
    rd(8'h40, 0, 32'h0, "R12 status cleared by fall");

    wr(8'h10, 32'h0000_3004);
    wr(8'h81, 32'h0000_0200);
    wr(8'h20, 32'h20);
    set_in(5, 1'b1);
    chk_irq(16'h0040, "R2 R3 R6 core1 line2");
    rd(8'h81, 0, 32'h0000_0200, "R3 route byte readback");

    wr(8'h10, 32'h0000_3008);
    chk_irq(16'h0040, "R11 line change keeps pending");

    wr(8'h40, 32'h20, 2'd1);
    chk_irq(16'h0000, "R9 write-one-to-clear");
    rd(8'h40, 1, 32'h0, "R9 core1 bank cleared");
    rd(8'h30, 0, 32'h20, "R1 raw unaffected by clear");
    set_in(5, 1'b0);

    wr(8'h22, 32'h2);
    wr(8'h21, 32'h2);
    set_in(33, 1'b1);
    chk_irq(16'h0001, "R2 high fallback to line0");
    wr(8'h88, 32'h0000_0800);
    chk_irq(16'h1000, "R10 reroute to core3");
    rd(8'h41, 3, 32'h2, "R10 new core status");
    rd(8'h41, 0, 32'h0, "R10 old core status");

    wr(8'h00, 32'h1);
    wr(8'h88, 32'h0000_0900);
    chk_irq(16'h1000, "R5 invalid core ignored");
    rd(8'h88, 0, 32'h0000_0900, "R5 ignored byte still stored");
    wr(8'h88, 32'h0000_0200);
    chk_irq(16'h0100, "R4 encoded core2");
    wr(8'h00, 32'h0);
    wr(8'h88, 32'h0000_8000);
    chk_irq(16'h0001, "R3 one-hot fallback core0");

    wr(8'h21, 32'h0);
    chk_irq(16'h0000, "R8 disabling withdraws");
    rd(8'h31, 0, 32'h2, "R1 raw while disabled");

    wr(8'h21, 32'h6);
    set_in(34, 1'b1);
    chk_irq(16'h0001, "R7 two pending on line");
    set_in(33, 1'b0);
    chk_irq(16'h0001, "R7 one remains");
    set_in(34, 1'b0);
    chk_irq(16'h0000, "R7 last leaves");

    rd(8'h70, 0, 32'h0, "R14 unmapped read");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule